// File: doc/BRIEF.md
# Serial-Loaded Line Memory Read Addresser

This block produces the read pointer for a memory organized as lines of bits, such as a video field store. The pointer has two parts. A line address selects the row. A bit address selects the starting bit within that row and then steps through it one position per read clock. Start values arrive one bit per clock on two dedicated serial pins: one pin carries the line value and the other carries the bit value. A mode input chooses what each clock does. When the mode input is low, the dual-purpose input acts as a load strobe. When the mode input is high, the clock is a reset cycle: the dual-purpose input then requests a line clear, and a separate step input advances the line without reloading it.

Typical use: shift the line and bit start values in over ten clocks and pulse the strobe on the last bit. The read then proceeds with the bit pointer counting up. At the end of a line, a single reset cycle with the step input high moves to the next row and returns the bit pointer to zero. The memory array, data path and write side are outside this block.

Top module: `line_rd_addr`

## Requirements
- R1: The line serial input is sampled at every rising clock edge, most significant bit first. The value offered for loading is the last 9 bits sampled, including the bit sampled at the loading edge itself.
- R2: The bit serial input is sampled the same way on its own pin. The value offered for loading is the last 10 bits sampled, including the bit sampled at the loading edge.
- R3: An edge with `rd_rst_mode`=0 and `en_clr`=1 is a load cycle. At that edge both `line_addr` and `bit_addr` take the assembled serial values.
- R4: An edge with `rd_rst_mode`=0 and `en_clr`=0 is a run cycle. At that edge `bit_addr` increments by one, wrapping from 1023 to 0, and `line_addr` is unchanged.
- R5: At every edge with `rd_rst_mode`=1, `bit_addr` becomes 0.
- R6: At an edge with `rd_rst_mode`=1 and `en_clr`=1, `line_addr` becomes 0.
- R7: At an edge with `rd_rst_mode`=1, `en_clr`=0 and `x_step`=1, `line_addr` increments by one, wrapping from 511 to 0.
- R8: When `en_clr` and `x_step` are both 1 in a reset cycle, the clear wins and `line_addr` becomes 0.
- R9: `line_addr` is unchanged at an edge with `rd_rst_mode`=1, `en_clr`=0 and `x_step`=0. `x_step` has no effect outside reset cycles.
- R10: A synchronous active-high `rst` clears both serial shift registers and both address registers. The outputs read 0 after the edge.
- R11: Serial sampling continues in every cycle type, so bits shifted during run or reset cycles count toward the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_rst_mode | input | 1 | 0: load or run cycle, 1: reset cycle |
| en_clr | input | 1 | Load strobe in mode 0, line-clear request in mode 1 |
| x_step | input | 1 | Line increment request in reset cycles |
| x_sdi | input | 1 | Serial line-address bit, MSB first |
| y_sdi | input | 1 | Serial bit-address bit, MSB first |
| line_addr | output | 9 | Working line address |
| bit_addr | output | 10 | Working bit-in-line address |

## Verification
The bench builds the block at its default widths of 9 line bits and 10 bit-address bits. At these widths both wrap points (511 and 1023) are reached within a few clocks: the bench loads start values just below the limits and then runs or steps across them. The short widths also let a behavioural integer model, compared on every clock, cover every mix of load, run, clear, step and clear-with-step, including streams where bits shifted outside load cycles feed the next load.

// File: rtl/lra_pkg.sv
package lra_pkg;

    localparam int LINE_W_DEF = 9;
    localparam int BIT_W_DEF  = 10;

    typedef enum logic [1:0] {
        CYC_RUN   = 2'd0,
        CYC_LOAD  = 2'd1,
        CYC_RESET = 2'd2
    } cyc_e;

    typedef struct packed {
        logic clr;
        logic step;
    } line_req_t;

    function automatic cyc_e decode_cycle(input logic mode, input logic strobe);
        if (mode)
            return CYC_RESET;
        else if (strobe)
            return CYC_LOAD;
        else
            return CYC_RUN;
    endfunction

endpackage

// File: rtl/lra_shifter.sv
module lra_shifter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sdi,
    output logic [W-1:0] word
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else
            sh_q <= {sh_q[W-2:0], sdi};
    end

    // Value including the bit sampled at this edge
    assign word = {sh_q[W-2:0], sdi};

    a_r11_keeps_shifting: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sh_q[0] == $past(sdi));
endmodule

// File: rtl/lra_line_ptr.sv
module lra_line_ptr
    import lra_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  cyc_e         kind,
    input  line_req_t    req,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d;

    always_comb begin
        q_d = q;
        unique case (kind)
            CYC_LOAD:  q_d = load_val;
            CYC_RESET: begin
                if (req.clr)
                    q_d = '0;
                else if (req.step)
                    q_d = q + W'(1);
            end
            default:   q_d = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= q_d;
    end

    a_r3_line_load: assert property (@(posedge clk) disable iff (rst)
        kind == CYC_LOAD |=> q == $past(load_val));
    a_r6_r8_line_clear: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_RESET && req.clr) |=> q == '0);
    a_r7_line_step: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_RESET && !req.clr && req.step) |=> q == W'($past(q) + 1));
    a_r9_line_hold: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_RUN || (kind == CYC_RESET && !req.clr && !req.step)) |=> $stable(q));
    a_r10_line_rst: assert property (@(posedge clk)
        rst |=> q == '0);
endmodule

// File: rtl/lra_bit_ptr.sv
module lra_bit_ptr
    import lra_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  cyc_e         kind,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d;

    always_comb begin
        unique case (kind)
            CYC_LOAD:  q_d = load_val;
            CYC_RESET: q_d = '0;
            default:   q_d = q + W'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= q_d;
    end

    a_r3_bit_load: assert property (@(posedge clk) disable iff (rst)
        kind == CYC_LOAD |=> q == $past(load_val));
    a_r4_bit_step: assert property (@(posedge clk) disable iff (rst)
        kind == CYC_RUN |=> q == W'($past(q) + 1));
    a_r5_bit_clear: assert property (@(posedge clk) disable iff (rst)
        kind == CYC_RESET |=> q == '0);
    a_r10_bit_rst: assert property (@(posedge clk)
        rst |=> q == '0);
endmodule

// File: rtl/line_rd_addr.sv
module line_rd_addr
    import lra_pkg::*;
#(
    parameter int LINE_W = LINE_W_DEF,
    parameter int BIT_W  = BIT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_rst_mode,
    input  logic              en_clr,
    input  logic              x_step,
    input  logic              x_sdi,
    input  logic              y_sdi,
    output logic [LINE_W-1:0] line_addr,
    output logic [BIT_W-1:0]  bit_addr
);
    cyc_e              kind;
    line_req_t         lreq;
    logic [LINE_W-1:0] x_word;
    logic [BIT_W-1:0]  y_word;

    assign kind      = decode_cycle(rd_rst_mode, en_clr);
    assign lreq.clr  = en_clr;
    assign lreq.step = x_step;

    lra_shifter #(.W(LINE_W)) u_xsh (
        .clk(clk), .rst(rst), .sdi(x_sdi), .word(x_word)
    );

    lra_shifter #(.W(BIT_W)) u_ysh (
        .clk(clk), .rst(rst), .sdi(y_sdi), .word(y_word)
    );

    lra_line_ptr #(.W(LINE_W)) u_line (
        .clk(clk), .rst(rst), .kind(kind), .req(lreq),
        .load_val(x_word), .q(line_addr)
    );

    lra_bit_ptr #(.W(BIT_W)) u_bit (
        .clk(clk), .rst(rst), .kind(kind),
        .load_val(y_word), .q(bit_addr)
    );

    a_r9_step_ignored_in_run: assert property (@(posedge clk) disable iff (rst)
        (!rd_rst_mode && !en_clr && x_step) |=> $stable(line_addr));
endmodule

// File: tb/line_rd_addr_tb_top.sv
module line_rd_addr_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0, dual = 1'b0, inc = 1'b0, xb = 1'b0, yb = 1'b0;
    logic [8:0] line_addr;
    logic [9:0] bit_addr;

    int n_tests = 0, n_fail = 0;
    int m_xsh = 0, m_ysh = 0, m_x = 0, m_y = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    line_rd_addr dut_i (
        .clk(clk), .rst(rst), .rd_rst_mode(mode), .en_clr(dual),
        .x_step(inc), .x_sdi(xb), .y_sdi(yb),
        .line_addr(line_addr), .bit_addr(bit_addr)
    );

    // Behavioural reference model
    always @(posedge clk) begin
        int nx, ny;
        nx = ((m_xsh << 1) | int'(xb)) % 512;
        ny = ((m_ysh << 1) | int'(yb)) % 1024;
        if (rst) begin
            m_xsh <= 0; m_ysh <= 0; m_x <= 0; m_y <= 0;
        end else begin
            m_xsh <= nx; m_ysh <= ny;
            if (!mode && dual) begin
                m_x <= nx; m_y <= ny;
            end else if (!mode) begin
                m_y <= (m_y + 1) % 1024;
            end else begin
                m_y <= 0;
                if (dual) m_x <= 0;
                else if (inc) m_x <= (m_x + 1) % 512;
            end
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic md, input logic d, input logic i,
                        input logic x, input logic y, input string tag);
        rst = r; mode = md; dual = d; inc = i; xb = x; yb = y;
        @(posedge clk);
        @(negedge clk);
        cmp({tag, " line"}, int'(line_addr), m_x);
        cmp({tag, " bit"},  int'(bit_addr),  m_y);
    endtask

    // Shift 10 clocks in run mode, pulse the load strobe on the last one
    task automatic load(input int xv, input int yv, input logic md_noise);
        for (int k = 0; k < 10; k++) begin
            logic xbit, ybit, ld;
            xbit = (k == 0) ? 1'b1 : 1'(xv >> (9 - k));
            ybit = 1'(yv >> (9 - k));
            ld = (k == 9);
            step(0, ld ? 1'b0 : md_noise, ld, 1'b0, xbit, ybit,
                 ld ? "R1 R2 R3 load" : "R11 shift");
        end
        cmp("R3 line value", int'(line_addr), xv);
        cmp("R3 bit value",  int'(bit_addr),  yv);
    endtask

    initial begin
        @(negedge clk);
        step(1, 0, 0, 0, 1, 1, "R10 reset");
        step(1, 1, 1, 1, 1, 1, "R10 reset");
        cmp("R10 line zero", int'(line_addr), 0);
        cmp("R10 bit zero",  int'(bit_addr),  0);

        load(5, 7, 1'b0);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 0, 0, "R4 R9 run, step ignored");
        cmp("R4 bit count", int'(bit_addr), 10);
        cmp("R9 line kept", int'(line_addr), 5);

        load(510, 1022, 1'b0);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, "R4 wrap");
        cmp("R4 bit wrap", int'(bit_addr), 1);
        step(0, 1, 0, 1, 0, 0, "R7 step");
        cmp("R7 line 511", int'(line_addr), 511);
        cmp("R5 bit cleared", int'(bit_addr), 0);
        step(0, 1, 0, 1, 0, 0, "R7 wrap");
        cmp("R7 line wrap", int'(line_addr), 0);

        load(341, 682, 1'b1);
        step(0, 1, 0, 0, 0, 0, "R9 hold");
        cmp("R9 line held", int'(line_addr), 341);
        step(0, 1, 1, 1, 0, 0, "R8 clear wins");
        cmp("R8 line zero", int'(line_addr), 0);
        load(100, 200, 1'b0);
        step(0, 1, 1, 0, 0, 0, "R6 clear");
        cmp("R6 line zero", int'(line_addr), 0);

        for (int k = 0; k < 400; k++)
            step(($urandom % 97) == 0, 1'($urandom % 4 == 0), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), "R1 R2 R11 mix");

        load(17, 33, 1'b0);
        step(1, 0, 0, 0, 0, 0, "R10 mid reset");
        cmp("R10 line zero late", int'(line_addr), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule